// File: doc/BRIEF.md
# Burst Address Counter Register

This block generates the per-cycle access address for one port of a synchronous burst memory. On every rising clock edge it samples three active-low controls (clear, address strobe and advance) together with an external address bus. It then settles on a single internal address, which the memory uses for the access in the following cycle.

The controls are ranked. Clear forces address zero. The strobe loads the external bus. Advance steps the previous address by one, and with none of them asserted the address is held. The result sits in a register, so the next cycle can step from it. No chip-select input exists, so the counter acts whether or not the port is selected. Clearing costs no idle cycle: the cycle right after a clear already accesses address zero.

Top module: `bac_top`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_addr` becomes 0 after that edge.
- R2: When `clr_n` is 0 at a rising edge, `acc_addr` becomes 0 after that edge, whatever the values of `stb_n`, `adv_n` and `ext_addr`.
- R3: When `clr_n` is 1 and `stb_n` is 0 at a rising edge, `acc_addr` takes the value of `ext_addr` sampled at that edge, whatever the value of `adv_n`.
- R4: When `clr_n` and `stb_n` are 1 and `adv_n` is 0 at a rising edge, `acc_addr` becomes its previous value plus one.
- R5: When `clr_n`, `stb_n` and `adv_n` are all 1 at a rising edge, `acc_addr` keeps its value, and changes on `ext_addr` have no effect.
- R6: Stepping from the all-ones address gives address 0.
- R7: Each rising edge applies exactly one operation, with no idle cycle in between. A clear, load or step at one edge may be followed at once by a different operation at the next edge, and each result appears in the cycle straight after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | External address, loaded while the strobe is asserted |
| stb_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Counter advance, active low |
| clr_n | input | 1 | Counter clear to address 0, active low, highest priority |
| acc_addr | output | AW | Registered internal address used for the current access |

## Verification
The bound checker covers every control combination on every cycle. It checks the result of a clear, a load, a step and a hold against the previous cycle's inputs and address, and it checks the all-ones-to-zero wrap. Only the bench's scenarios can show the rest. These include the priority conflicts driven on purpose: clear against load, and load against advance. They also cover a long burst that crosses the wrap point, and a clear followed straight away by loads and steps with no idle cycle.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } bac_op_e;

    typedef struct packed {
        logic clr;
        logic stb;
        logic adv;
    } bac_ctl_s;

    // Rank the asserted controls: clear, then load, then step.
    function automatic bac_op_e pick_op(input bac_ctl_s c);
        if (c.clr)      return OP_CLEAR;
        else if (c.stb) return OP_LOAD;
        else if (c.adv) return OP_STEP;
        else            return OP_HOLD;
    endfunction

endpackage

// File: rtl/bac_decode.sv
module bac_decode
    import bac_pkg::*;
(
    input  logic    clr_n,
    input  logic    stb_n,
    input  logic    adv_n,
    output bac_op_e op
);
    bac_ctl_s ctl;

    always_comb begin
        ctl.clr = ~clr_n;
        ctl.stb = ~stb_n;
        ctl.adv = ~adv_n;
        op      = pick_op(ctl);
    end
endmodule

// File: rtl/bac_next.sv
module bac_next
    import bac_pkg::*;
#(
    parameter int AW = 16
) (
    input  bac_op_e       op,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ext,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ext;
            OP_STEP:  nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bac_top.sv
module bac_top
    import bac_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          stb_n,
    input  logic          adv_n,
    input  logic          clr_n,
    output logic [AW-1:0] acc_addr
);
    bac_op_e       op;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    bac_decode u_dec (
        .clr_n (clr_n),
        .stb_n (stb_n),
        .adv_n (adv_n),
        .op    (op)
    );

    bac_next #(.AW(AW)) u_nxt (
        .op  (op),
        .cur (addr_q),
        .ext (ext_addr),
        .nxt (addr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign acc_addr = addr_q;
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          stb_n,
    input logic          adv_n,
    input logic          clr_n,
    input logic [AW-1:0] acc_addr
);
    localparam logic [AW-1:0] ALL1 = {AW{1'b1}};

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> acc_addr == '0);

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> acc_addr == '0);

    assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !stb_n) |=> acc_addr == $past(ext_addr));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_n && stb_n && !adv_n) |=> acc_addr == AW'($past(acc_addr) + AW'(1)));

    assert_hold_still_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_n && stb_n && adv_n) |=> $stable(acc_addr));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_n && stb_n && !adv_n && acc_addr == ALL1) |=> acc_addr == '0);
endmodule

bind bac_top bac_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .stb_n    (stb_n),
    .adv_n    (adv_n),
    .clr_n    (clr_n),
    .acc_addr (acc_addr)
);

// File: tb/sim_bac_top.sv
module sim_bac_top;
    localparam int AW = 16;
    localparam logic [AW-1:0] ALL1 = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          stb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] acc_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [AW-1:0] exp_q = '0;

    always #4 clk = ~clk;

    bac_top #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .stb_n(stb_n), .adv_n(adv_n), .clr_n(clr_n),
        .acc_addr(acc_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (acc_addr !== exp) begin
            errors++;
            $display("FAIL %s: acc_addr=%h expected=%h", tag, acc_addr, exp);
        end
    endtask

    // Drive one cycle of controls at the falling edge, sample just after the rising edge.
    task automatic cycle(input logic c, input logic s, input logic a, input logic [AW-1:0] ea);
        @(negedge clk);
        clr_n = c; stb_n = s; adv_n = a; ext_addr = ea;
        if (!c)      exp_q = '0;
        else if (!s) exp_q = ea;
        else if (!a) exp_q = exp_q + AW'(1);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0; exp_q = '0;
        check("R1 reset value", '0);
    endtask

    task automatic t_load;
        cycle(1, 0, 1, 16'h1234); check("R3 load", exp_q);
        cycle(1, 0, 0, 16'hBEEF); check("R3 load beats advance", 16'hBEEF);
    endtask

    task automatic t_clear;
        cycle(0, 0, 0, 16'h5555); check("R2 clear beats load and advance", '0);
        cycle(1, 0, 1, 16'h0A0A);
        cycle(0, 1, 1, 16'h0A0A); check("R2 clear alone", '0);
    endtask

    task automatic t_step;
        cycle(1, 0, 1, 16'h00F0);
        for (int i = 1; i <= 4; i++) begin
            cycle(1, 1, 0, 16'hFFFF);
            check("R4 step", 16'h00F0 + AW'(i));
        end
    endtask

    task automatic t_hold;
        cycle(1, 0, 1, 16'h4321);
        cycle(1, 1, 1, 16'h9999); check("R5 hold ignores ext_addr", 16'h4321);
        cycle(1, 1, 1, 16'h0000); check("R5 hold second cycle", 16'h4321);
    endtask

    task automatic t_wrap;
        cycle(1, 0, 1, ALL1 - AW'(1));
        cycle(1, 1, 0, '0); check("R6 step to all-ones", ALL1);
        cycle(1, 1, 0, '0); check("R6 wrap to zero", '0);
        cycle(1, 1, 0, '0); check("R6 step after wrap", 16'h0001);
    endtask

    task automatic t_back_to_back;
        cycle(1, 0, 1, 16'h0300); check("R7 load", 16'h0300);
        cycle(0, 1, 0, 16'h0000); check("R7 clear right after load", '0);
        cycle(1, 1, 0, 16'h0000); check("R7 step right after clear", 16'h0001);
        cycle(1, 0, 1, 16'h7000); check("R7 load right after step", 16'h7000);
        cycle(1, 1, 0, 16'h0000); check("R7 step right after load", 16'h7001);
        cycle(1, 1, 1, 16'h1111); check("R7 hold right after step", 16'h7001);
    endtask

    initial begin
        t_reset;
        t_load;
        t_clear;
        t_step;
        t_hold;
        t_wrap;
        t_back_to_back;
        cycle(1, 0, 1, 16'hAAAA);
        t_reset;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule